// File: doc/BRIEF.md
# Word-to-Byte Staging Buffer with Byte-Order Select

This block sits between a 16-bit host data register and a byte-wide serial engine. It holds up to four bytes in one shared shift buffer. A host write loads a 16-bit word as two bytes to transmit. A host read returns two received bytes packed into a 16-bit word. One byte-order input decides which half of the host word travels on the serial side first, in both directions.

Transmit and receive keep separate byte counts over the same storage. The engine takes bytes with a pop strobe and delivers bytes with a push strobe. Each operation reports its effect on the surrounding status register as one-cycle set and clear pulses: transmit-ready, transmit-underflow, receive-ready, receive-overrun, single-byte-data and access-ready. A read that drains the receive side during a master-receive transfer also asks the controller to drop its master bit.

At most one operation is taken in any cycle. The host has priority over the engine.

Top module: `word_byte_buf`

## Requirements
- R1: After reset both byte counts, `host_rdata_o`, `flag_set_o`, `flag_clr_o` and `master_clr_o` are zero. Each count always stays between 0 and LANES (4).
- R2: A granted host write is accepted only when the transmit count is at most LANES-2. An accepted write adds 2 to the transmit count. A write at a higher count leaves the count and the buffered bytes unchanged and emits no flag pulses.
- R3: Transmit bytes leave in first-in first-out order, with the older word going before the newer one. With `hi_first_i` = 1, bits 15:8 of a word are sent before bits 7:0. With `hi_first_i` = 0, bits 7:0 are sent first.
- R4: An accepted write clears transmit-underflow (flag bit 1). If the new transmit count is above 2, the write also clears transmit-ready (flag bit 0).
- R5: A granted pop with a non-zero transmit count returns the next byte on `tx_byte_o` in the same cycle and decrements the count. A granted pop with an empty transmit side returns 0 and sets transmit-underflow (bit 1). Every granted pop sets transmit-ready (bit 0).
- R6: Each granted push stores its byte in the next free lane, starting at lane 0, and increments the receive count. A push with the receive count at LANES drops its byte, leaves the count unchanged and sets receive-overrun (bit 3). Every granted push sets receive-ready (bit 2).
- R7: A host read returns its word on `host_rdata_o` one clock after the read strobe, and the value holds until the next read. The older of the two received bytes appears in bits 15:8 when `hi_first_i` = 1 and in bits 7:0 when `hi_first_i` = 0. A half with no received byte behind it reads as zero.
- R8: A read with a receive count of 1 sets single-byte-data (bit 4) and empties the receive side. A read with a count of 2 or more subtracts 2 from the count. If the count was above 2, the next two bytes move down to lanes 0 and 1.
- R9: Every read clears receive-overrun (bit 3). A read with an empty receive side returns 0 and has no other effect.
- R10: A read that drops the receive count to zero clears receive-ready (bit 2). If `master_rx_i` is also high, the same read sets access-ready (bit 5) and pulses `master_clr_o`.
- R11: Only one operation is taken per cycle. The priority order is host write, then host read, then pop, then push. `tx_grant_o` and `rx_grant_o` show in the same cycle whether a pop or a push was taken. A request that is not taken has no effect.
- R12: Flag and master-clear pulses appear in the cycle after the operation that caused them and last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hi_first_i | input | 1 | Byte order: 1 means the upper byte of the host word is on the serial side first |
| master_rx_i | input | 1 | A master-receive transfer is in progress |
| host_wr_i | input | 1 | Host data write strobe |
| host_wdata_i | input | 16 | Host write word |
| host_rd_i | input | 1 | Host data read strobe |
| host_rdata_o | output | 16 | Word returned by the last read |
| tx_pop_i | input | 1 | Engine requests a transmit byte |
| tx_grant_o | output | 1 | The pop is taken this cycle |
| tx_byte_o | output | 8 | Transmit byte, valid while a pop is granted |
| rx_push_i | input | 1 | Engine delivers a received byte |
| rx_byte_i | input | 8 | Received byte |
| rx_grant_o | output | 1 | The push is taken this cycle |
| tx_cnt_o | output | 3 | Bytes waiting to transmit |
| rx_cnt_o | output | 3 | Received bytes held |
| flag_set_o | output | 6 | One-cycle status set pulses: bit 0 transmit-ready, bit 1 transmit-underflow, bit 2 receive-ready, bit 3 receive-overrun, bit 4 single-byte-data, bit 5 access-ready |
| flag_clr_o | output | 6 | One-cycle status clear pulses, same bit positions as `flag_set_o` |
| master_clr_o | output | 1 | One-cycle request to clear the master bit |

## Verification
The following are checked on every cycle:
- count range;
- count arithmetic on accepted and rejected writes;
- transmit-ready on every pop;
- overrun and count hold on a full push;
- the single-byte read;
- overrun clear on every read;
- the tie between master clear and access-ready;
- one-hot arbitration;
- the zero byte on an empty pop.

Only the bench scenarios can show the byte order and the first-in first-out order across several words, in both byte-order settings. The same holds for the zero fill of half-empty reads, the movement of the upper pair on a read, and the requests that are silently dropped when strobes collide.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
  localparam int NFLAG     = 6;
  localparam int F_TX_RDY  = 0;
  localparam int F_TX_UDF  = 1;
  localparam int F_RX_RDY  = 2;
  localparam int F_RX_OVR  = 3;
  localparam int F_SBD     = 4;
  localparam int F_ACC_RDY = 5;

  typedef logic [NFLAG-1:0] flag_vec_t;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_WR   = 3'd1,
    OP_RD   = 3'd2,
    OP_POP  = 3'd3,
    OP_PUSH = 3'd4
  } op_e;
endpackage

// File: rtl/wbb_arb.sv
module wbb_arb
  import wbb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_wr_i,
  input  logic host_rd_i,
  input  logic tx_pop_i,
  input  logic rx_push_i,
  output op_e  op_o,
  output logic tx_grant_o,
  output logic rx_grant_o
);
  always_comb begin
    op_o = OP_NONE;
    if (host_wr_i)      op_o = OP_WR;
    else if (host_rd_i) op_o = OP_RD;
    else if (tx_pop_i)  op_o = OP_POP;
    else if (rx_push_i) op_o = OP_PUSH;
  end

  assign tx_grant_o = tx_pop_i & ~host_wr_i & ~host_rd_i;
  assign rx_grant_o = rx_push_i & ~host_wr_i & ~host_rd_i & ~tx_pop_i;

  // host strobes always beat engine grants
  p_grant_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_grant_o, rx_grant_o, host_wr_i && host_rd_i ? 1'b0 : (host_wr_i || host_rd_i)}));
  p_host_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i || host_rd_i) |-> !tx_grant_o && !rx_grant_o);
endmodule

// File: rtl/wbb_order.sv
module wbb_order #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              swap_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  assign word_o = swap_i ? {word_i[BYTE_W-1:0], word_i[WORD_W-1:BYTE_W]} : word_i;
endmodule

// File: rtl/wbb_lane_sel.sv
module wbb_lane_sel #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int IDX_W = $clog2(LANES),
  localparam int BUF_W = LANES * BYTE_W
) (
  input  logic [BUF_W-1:0]  buf_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [BYTE_W-1:0] lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = buf_i[g*BYTE_W +: BYTE_W];
  end

  assign byte_o = lane[idx_i];
endmodule

// File: rtl/wbb_core.sv
module wbb_core
  import wbb_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int BUF_W  = LANES * BYTE_W,
  localparam int CNT_W  = $clog2(LANES + 1),
  localparam int IDX_W  = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic              master_rx_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic [BUF_W-1:0]  buf_o,
  output logic [WORD_W-1:0] rd_pair_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  tx_cnt_o,
  output logic [CNT_W-1:0]  rx_cnt_o,
  output flag_vec_t         flag_set_o,
  output flag_vec_t         flag_clr_o,
  output logic              master_clr_o
);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_TWO  = CNT_W'(2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(LANES);
  localparam logic [CNT_W-1:0] WR_MAX   = CNT_W'(LANES - 2);

  logic [BUF_W-1:0]  buf_q, buf_d;
  logic [CNT_W-1:0]  tx_q, tx_d, rx_q, rx_d;
  logic [WORD_W-1:0] rdata_q, rdata_d;
  flag_vec_t         set_q, set_d, clr_q, clr_d;
  logic              mclr_q, mclr_d;
  logic              drained;
  logic [IDX_W-1:0]  rx_idx;

  assign rx_idx = IDX_W'(rx_q);

  // unreceived lanes read as zero
  assign rd_pair_o[BYTE_W-1:0]      = (rx_q >= CNT_ONE) ? buf_q[BYTE_W-1:0] : '0;
  assign rd_pair_o[WORD_W-1:BYTE_W] = (rx_q >= CNT_TWO) ? buf_q[WORD_W-1:BYTE_W] : '0;

  always_comb begin
    buf_d   = buf_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    rdata_d = rdata_q;
    set_d   = '0;
    clr_d   = '0;
    mclr_d  = 1'b0;
    drained = 1'b0;
    unique case (op_i)
      OP_WR: begin
        if (tx_q <= WR_MAX) begin
          buf_d = {buf_q[BUF_W-WORD_W-1:0], wr_word_i};
          tx_d  = tx_q + CNT_TWO;
          clr_d[F_TX_UDF] = 1'b1;
          if (tx_d > CNT_TWO) clr_d[F_TX_RDY] = 1'b1;
        end
      end
      OP_POP: begin
        if (tx_q != '0) tx_d = tx_q - CNT_ONE;
        else            set_d[F_TX_UDF] = 1'b1;
        set_d[F_TX_RDY] = 1'b1;
      end
      OP_PUSH: begin
        if (rx_q < CNT_FULL) begin
          for (int i = 0; i < LANES; i++) begin
            if (IDX_W'(i) == rx_idx) buf_d[i*BYTE_W +: BYTE_W] = rx_byte_i;
          end
          rx_d = rx_q + CNT_ONE;
        end else begin
          set_d[F_RX_OVR] = 1'b1;
        end
        set_d[F_RX_RDY] = 1'b1;
      end
      OP_RD: begin
        rdata_d = rd_word_i;
        clr_d[F_RX_OVR] = 1'b1;
        if (rx_q == CNT_ONE) begin
          set_d[F_SBD] = 1'b1;
          rx_d    = '0;
          drained = 1'b1;
        end else if (rx_q >= CNT_TWO) begin
          if (rx_q > CNT_TWO) buf_d = {{WORD_W{1'b0}}, buf_q[BUF_W-1:WORD_W]};
          rx_d    = rx_q - CNT_TWO;
          drained = (rx_q == CNT_TWO);
        end
        if (drained) begin
          clr_d[F_RX_RDY] = 1'b1;
          if (master_rx_i) begin
            set_d[F_ACC_RDY] = 1'b1;
            mclr_d = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      rdata_q <= '0;
      set_q   <= '0;
      clr_q   <= '0;
      mclr_q  <= 1'b0;
    end else begin
      buf_q   <= buf_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      rdata_q <= rdata_d;
      set_q   <= set_d;
      clr_q   <= clr_d;
      mclr_q  <= mclr_d;
    end
  end

  assign buf_o        = buf_q;
  assign rdata_o      = rdata_q;
  assign tx_cnt_o     = tx_q;
  assign rx_cnt_o     = rx_q;
  assign flag_set_o   = set_q;
  assign flag_clr_o   = clr_q;
  assign master_clr_o = mclr_q;

  p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_q <= CNT_FULL && rx_q <= CNT_FULL);
  p_wr_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_WR && tx_q <= WR_MAX) |=> tx_q == $past(tx_q) + CNT_TWO);
  p_wr_reject_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_WR && tx_q > WR_MAX) |=> $stable(tx_q) && $stable(buf_q) && flag_clr_o == '0);
  p_pop_rdy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_POP) |=> flag_set_o[F_TX_RDY]);
  p_push_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_PUSH && rx_q == CNT_FULL) |=> flag_set_o[F_RX_OVR] && $stable(rx_q));
  p_single_rd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_RD && rx_q == CNT_ONE) |=> flag_set_o[F_SBD] && rx_q == '0);
  p_rd_ovr_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_RD) |=> flag_clr_o[F_RX_OVR]);
  p_mclr_acc_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_clr_o |-> flag_set_o[F_ACC_RDY] && flag_clr_o[F_RX_RDY] && rx_q == '0);
endmodule

// File: rtl/word_byte_buf.sv
module word_byte_buf
  import wbb_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int BUF_W  = LANES * BYTE_W,
  localparam int CNT_W  = $clog2(LANES + 1),
  localparam int IDX_W  = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hi_first_i,
  input  logic              master_rx_i,
  input  logic              host_wr_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  input  logic              host_rd_i,
  output logic [WORD_W-1:0] host_rdata_o,
  input  logic              tx_pop_i,
  output logic              tx_grant_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  input  logic              rx_push_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic              rx_grant_o,
  output logic [CNT_W-1:0]  tx_cnt_o,
  output logic [CNT_W-1:0]  rx_cnt_o,
  output logic [NFLAG-1:0]  flag_set_o,
  output logic [NFLAG-1:0]  flag_clr_o,
  output logic              master_clr_o
);
  op_e               op;
  logic [WORD_W-1:0] wr_word, rd_pair, rd_word;
  logic [BUF_W-1:0]  buf_q;
  logic [BYTE_W-1:0] lane_byte;
  logic [IDX_W-1:0]  tx_idx;

  wbb_arb i_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .host_wr_i  (host_wr_i),
    .host_rd_i  (host_rd_i),
    .tx_pop_i   (tx_pop_i),
    .rx_push_i  (rx_push_i),
    .op_o       (op),
    .tx_grant_o (tx_grant_o),
    .rx_grant_o (rx_grant_o)
  );

  // the pair in lanes 1:0 leaves lane 1 first
  wbb_order #(.BYTE_W(BYTE_W)) i_wr_order (
    .swap_i (~hi_first_i),
    .word_i (host_wdata_i),
    .word_o (wr_word)
  );

  // the older received byte sits in lane 0
  wbb_order #(.BYTE_W(BYTE_W)) i_rd_order (
    .swap_i (hi_first_i),
    .word_i (rd_pair),
    .word_o (rd_word)
  );

  wbb_core #(.BYTE_W(BYTE_W), .LANES(LANES)) i_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .op_i         (op),
    .master_rx_i  (master_rx_i),
    .wr_word_i    (wr_word),
    .rx_byte_i    (rx_byte_i),
    .rd_word_i    (rd_word),
    .buf_o        (buf_q),
    .rd_pair_o    (rd_pair),
    .rdata_o      (host_rdata_o),
    .tx_cnt_o     (tx_cnt_o),
    .rx_cnt_o     (rx_cnt_o),
    .flag_set_o   (flag_set_o),
    .flag_clr_o   (flag_clr_o),
    .master_clr_o (master_clr_o)
  );

  assign tx_idx = IDX_W'(tx_cnt_o - CNT_W'(1));

  wbb_lane_sel #(.BYTE_W(BYTE_W), .LANES(LANES)) i_tx_sel (
    .buf_i  (buf_q),
    .idx_i  (tx_idx),
    .byte_o (lane_byte)
  );

  assign tx_byte_o = (tx_cnt_o == '0) ? '0 : lane_byte;

  p_empty_pop_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_grant_o && tx_cnt_o == '0) |-> tx_byte_o == '0);
endmodule

// File: tb/test_word_byte_buf.sv
module test_word_byte_buf;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hi_first_i = 1'b0, master_rx_i = 1'b0;
  logic        host_wr_i = 1'b0, host_rd_i = 1'b0;
  logic [15:0] host_wdata_i = '0;
  logic [15:0] host_rdata_o;
  logic        tx_pop_i = 1'b0, tx_grant_o;
  logic [7:0]  tx_byte_o;
  logic        rx_push_i = 1'b0, rx_grant_o;
  logic [7:0]  rx_byte_i = '0;
  logic [2:0]  tx_cnt_o, rx_cnt_o;
  logic [5:0]  flag_set_o, flag_clr_o;
  logic        master_clr_o;

  int checks = 0, errors = 0;
  int model_tx = 0;
  logic [7:0] exp_q[$];

  always #10 clk_i = ~clk_i;

  word_byte_buf i_word_byte_buf (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // scoreboard monitor: every granted pop must match the next expected byte
  always @(posedge clk_i) begin
    if (rst_ni && tx_pop_i && tx_grant_o) begin
      logic [7:0] e;
      e = (exp_q.size() != 0) ? exp_q.pop_front() : 8'h00;
      chk(tx_byte_o == e, "R3", "tx byte", tx_byte_o, e);
    end
  end

  // driver: queue the bytes a write should produce when it is accepted
  task automatic do_wr(input logic [15:0] w);
    if (model_tx <= 2) begin
      if (hi_first_i) begin exp_q.push_back(w[15:8]); exp_q.push_back(w[7:0]); end
      else            begin exp_q.push_back(w[7:0]);  exp_q.push_back(w[15:8]); end
      model_tx += 2;
    end
    host_wr_i = 1'b1; host_wdata_i = w;
    @(negedge clk_i);
    host_wr_i = 1'b0;
  endtask

  task automatic do_pop();
    if (model_tx > 0) model_tx--;
    tx_pop_i = 1'b1;
    @(negedge clk_i);
    tx_pop_i = 1'b0;
  endtask

  task automatic do_push(input logic [7:0] b);
    rx_push_i = 1'b1; rx_byte_i = b;
    @(negedge clk_i);
    rx_push_i = 1'b0;
  endtask

  task automatic do_rd();
    host_rd_i = 1'b1;
    @(negedge clk_i);
    host_rd_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    report();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(tx_cnt_o == 0 && rx_cnt_o == 0, "R1", "reset counts", {tx_cnt_o, rx_cnt_o}, 0);
    chk(host_rdata_o == 0, "R1", "reset rdata", host_rdata_o, 0);
    chk(flag_set_o == 0 && flag_clr_o == 0 && !master_clr_o, "R1", "reset pulses",
        {master_clr_o, flag_set_o, flag_clr_o}, 0);

    // low byte first
    hi_first_i = 1'b0;
    do_wr(16'hA1B2);
    chk(tx_cnt_o == 2, "R2", "tx count after write", tx_cnt_o, 2);
    chk(flag_clr_o == 6'b000010, "R4", "write clear pulses", flag_clr_o, 6'b000010);
    @(negedge clk_i);
    chk(flag_clr_o == 0, "R12", "pulse lasts one cycle", flag_clr_o, 0);
    do_pop();
    chk(flag_set_o == 6'b000001, "R5", "pop set pulses", flag_set_o, 6'b000001);
    chk(tx_cnt_o == 1, "R5", "tx count after pop", tx_cnt_o, 1);
    do_pop();
    do_pop();
    chk(flag_set_o == 6'b000011, "R5", "empty pop set pulses", flag_set_o, 6'b000011);
    chk(tx_cnt_o == 0, "R5", "tx count stays zero", tx_cnt_o, 0);

    // high byte first, fill, reject
    hi_first_i = 1'b1;
    do_wr(16'h1234);
    do_wr(16'h5678);
    chk(tx_cnt_o == 4, "R2", "tx count full", tx_cnt_o, 4);
    chk(flag_clr_o == 6'b000011, "R4", "write above two clears ready", flag_clr_o, 6'b000011);
    do_wr(16'h9ABC);
    chk(tx_cnt_o == 4, "R2", "rejected write count", tx_cnt_o, 4);
    chk(flag_clr_o == 0, "R2", "rejected write pulses", flag_clr_o, 0);
    repeat (4) do_pop();
    chk(tx_cnt_o == 0, "R3", "tx drained", tx_cnt_o, 0);
    chk(exp_q.size() == 0, "R3", "all bytes sent", exp_q.size(), 0);

    // receive, low byte first, no master
    hi_first_i = 1'b0; master_rx_i = 1'b0;
    do_push(8'h11);
    chk(flag_set_o == 6'b000100, "R6", "push set ready", flag_set_o, 6'b000100);
    do_push(8'h22);
    do_push(8'h33);
    chk(rx_cnt_o == 3, "R6", "rx count", rx_cnt_o, 3);
    do_rd();
    chk(host_rdata_o == 16'h2211, "R7", "read low first", host_rdata_o, 16'h2211);
    chk(rx_cnt_o == 1, "R8", "rx count after read", rx_cnt_o, 1);
    chk(flag_clr_o == 6'b001000 && flag_set_o == 0, "R9", "read clears overrun",
        {flag_set_o, flag_clr_o}, 6'b001000);
    do_rd();
    chk(host_rdata_o == 16'h0033, "R7", "single byte zero filled", host_rdata_o, 16'h0033);
    chk(rx_cnt_o == 0, "R8", "single byte empties", rx_cnt_o, 0);
    chk(flag_set_o == 6'b010000, "R8", "single byte flag", flag_set_o, 6'b010000);
    chk(flag_clr_o == 6'b001100 && !master_clr_o, "R10", "drain without master",
        {master_clr_o, flag_clr_o}, 6'b001100);

    // receive, high byte first, overrun, master
    hi_first_i = 1'b1; master_rx_i = 1'b1;
    do_push(8'h01); do_push(8'h02); do_push(8'h03); do_push(8'h04);
    do_push(8'h05);
    chk(flag_set_o == 6'b001100, "R6", "overrun set", flag_set_o, 6'b001100);
    chk(rx_cnt_o == 4, "R6", "full count held", rx_cnt_o, 4);
    do_rd();
    chk(host_rdata_o == 16'h0102, "R7", "read high first", host_rdata_o, 16'h0102);
    chk(rx_cnt_o == 2, "R8", "count minus two", rx_cnt_o, 2);
    do_rd();
    chk(host_rdata_o == 16'h0304, "R8", "upper pair moved down", host_rdata_o, 16'h0304);
    chk(flag_set_o == 6'b100000 && master_clr_o, "R10", "master drain",
        {master_clr_o, flag_set_o}, 7'b1100000);
    chk(flag_clr_o == 6'b001100, "R10", "drain clears ready", flag_clr_o, 6'b001100);

    // empty read
    do_rd();
    chk(host_rdata_o == 0 && rx_cnt_o == 0 && tx_cnt_o == 0, "R9", "empty read",
        {host_rdata_o, rx_cnt_o, tx_cnt_o}, 0);
    chk(flag_set_o == 0 && flag_clr_o == 6'b001000 && !master_clr_o, "R9", "empty read pulses",
        {master_clr_o, flag_set_o, flag_clr_o}, 6'b001000);

    // arbitration
    master_rx_i = 1'b0;
    host_wr_i = 1'b1; host_wdata_i = 16'h00FF; tx_pop_i = 1'b1;
    exp_q.push_back(8'h00); exp_q.push_back(8'hFF); model_tx = 2;
    #1 chk(!tx_grant_o, "R11", "write beats pop", tx_grant_o, 0);
    @(negedge clk_i);
    host_wr_i = 1'b0; tx_pop_i = 1'b0;
    chk(tx_cnt_o == 2 && flag_set_o == 0, "R11", "only write taken", {tx_cnt_o, flag_set_o}, 9'h080);
    host_rd_i = 1'b1; rx_push_i = 1'b1; rx_byte_i = 8'hAA;
    #1 chk(!rx_grant_o, "R11", "read beats push", rx_grant_o, 0);
    @(negedge clk_i);
    host_rd_i = 1'b0; rx_push_i = 1'b0;
    chk(rx_cnt_o == 0 && flag_set_o == 0, "R11", "push dropped", {rx_cnt_o, flag_set_o}, 0);
    tx_pop_i = 1'b1; rx_push_i = 1'b1;
    #1 chk(tx_grant_o && !rx_grant_o, "R11", "pop beats push", {tx_grant_o, rx_grant_o}, 2'b10);
    @(negedge clk_i);
    tx_pop_i = 1'b0; rx_push_i = 1'b0;
    chk(rx_cnt_o == 0 && tx_cnt_o == 1, "R11", "counts after pop and push",
        {tx_cnt_o, rx_cnt_o}, 6'o10);
    do_pop();
    chk(exp_q.size() == 0, "R3", "arbitration bytes sent", exp_q.size(), 0);
    report();
  end
endmodule